// File: doc/BRIEF.md
# Interrupt Latency Measurement Unit

This block measures how long a host takes to answer an interrupt. On a start command it raises a level-sensitive interrupt request and counts clock cycles until the host acknowledges. The acknowledge ends the trial and freezes the result. Across many trials it keeps the minimum and maximum latency, the number of completed trials, the sum of latencies and the sum of their squares. Software divides those to get the mean and the variance.

Alongside the trial logic is a free-running timestamp counter. It advances on every clock, or on each rising edge of an external tick input, as the host selects. A rising edge on an external trigger copies the counter into a capture register. Both external inputs are asynchronous and pass through synchronizers before their edges are detected. The host-facing register decode is left to a bus bridge outside this block. Commands arrive here as single-cycle strobes and every result is a plain output.

Top module: `irq_latency_unit`

## Requirements
- R1: After reset, and after a clear command, minLatency is all ones and maxLatency, sampleCount, sumLatency, sumSquares and latOverflow are zero. After reset irqOut is low.
- R2: A startTrial strobe sampled while no trial runs raises irqOut on the next cycle and restarts latencyNow from zero. A startTrial strobe sampled during a trial is ignored.
- R3: An ackIrq strobe sampled during a trial drops irqOut on the next cycle. lastLatency then holds the number of clock edges from the start edge to the acknowledge edge, so an acknowledge on the edge right after the start gives 1. An ackIrq sampled while no trial runs changes nothing.
- R4: The latency count saturates at all ones (2^LAT_W-1). latOverflow is set only when a trial outlasts that value. It stays set until a clear command or reset.
- R5: Each completed trial lowers minLatency if its latency is smaller and raises maxLatency if it is larger. The first trial after a clear therefore sets both.
- R6: Each completed trial adds one to sampleCount, its latency to sumLatency and the square of its latency to sumSquares. All three saturate at all ones instead of wrapping.
- R7: When a clear command and a trial completion fall on the same edge, the clear wins for the statistics and the trial is not counted. lastLatency still takes that trial's latency.
- R8: With tickSel at 0, timeStamp adds one on every clock and wraps modulo 2^TS_W. With tickSel at 1, it adds one for each rising edge of extTick and holds otherwise.
- R9: A rising edge of extTrigger loads captureValue once with the timeStamp value held at the edge on which the synchronized edge is seen. With tickSel at 0 that is the value present before the input rose, plus 2. Holding extTrigger high does not capture again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| startTrial | input | 1 | Strobe: begin a trial |
| ackIrq | input | 1 | Strobe: host acknowledge |
| clearStats | input | 1 | Strobe: clear statistics and overflow flag |
| tickSel | input | 1 | Timestamp source: 0 bus clock, 1 external tick |
| extTick | input | 1 | Asynchronous external tick |
| extTrigger | input | 1 | Asynchronous capture trigger |
| irqOut | output | 1 | Level interrupt request |
| trialActive | output | 1 | A trial is running |
| latencyNow | output | LAT_W | Live cycle count of the current or last trial |
| lastLatency | output | LAT_W | Latency of the last completed trial |
| latOverflow | output | 1 | Sticky saturation flag |
| minLatency | output | LAT_W | Smallest latency since clear |
| maxLatency | output | LAT_W | Largest latency since clear |
| sampleCount | output | CNT_W | Completed trials since clear |
| sumLatency | output | SUM_W | Saturating sum of latencies |
| sumSquares | output | SQ_W | Saturating sum of squared latencies |
| timeStamp | output | TS_W | Free-running timestamp |
| captureValue | output | TS_W | Timestamp captured by the trigger |

## Verification
The collision of interest is a clear command on the same edge as a trial-ending acknowledge. The statistics update and the statistics reset then compete for the same registers. The bench drives ackIrq and clearStats on the same cycle. It expects every statistic at its cleared value, with lastLatency still set to that trial's latency. It also checks that a start during a trial is ignored, that an acknowledge while idle is ignored, and that a latency of exactly 2^LAT_W-1 does not set the overflow flag while 2^LAT_W does.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
  typedef struct packed {
    logic startPulse;
    logic endPulse;
    logic clearPulse;
  } ilm_strobe_t;
endpackage

// File: rtl/ilm_edge_sync.sv
module ilm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain     <= '0;
      prevLevel <= 1'b0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prevLevel <= chain[STAGES-1];
    end
  end

  assign riseOut = chain[STAGES-1] & ~prevLevel;
endmodule

// File: rtl/ilm_ctrl.sv
module ilm_ctrl
  import ilm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startTrial,
  input  logic        ackIrq,
  input  logic        clearStats,
  output ilm_strobe_t strobe,
  output logic        running
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state;

  logic takeStart, takeAck;
  assign takeStart = (state == ST_IDLE) && startTrial;
  assign takeAck   = (state == ST_RUN) && ackIrq;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (takeStart) state <= ST_RUN;
    else if (takeAck) state <= ST_IDLE;
  end

  assign running           = (state == ST_RUN);
  assign strobe.startPulse = takeStart;
  assign strobe.endPulse   = takeAck;
  assign strobe.clearPulse = clearStats;
endmodule

// File: rtl/ilm_datapath.sv
module ilm_datapath
  import ilm_pkg::*;
#(
  parameter int LAT_W = 32,
  parameter int CNT_W = 32,
  parameter int SUM_W = 48,
  parameter int SQ_W  = 64,
  parameter int TS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ilm_strobe_t       strobe,
  input  logic              running,
  input  logic              tickSel,
  input  logic              tickRise,
  input  logic              trigRise,
  output logic [LAT_W-1:0]  latCnt,
  output logic [LAT_W-1:0]  lastLat,
  output logic              ovfFlag,
  output logic [LAT_W-1:0]  minLat,
  output logic [LAT_W-1:0]  maxLat,
  output logic [CNT_W-1:0]  cntAcc,
  output logic [SUM_W-1:0]  sumAcc,
  output logic [SQ_W-1:0]   sqAcc,
  output logic [TS_W-1:0]   tsCnt,
  output logic [TS_W-1:0]   tsCap
);
  localparam int PROD_W = 2 * LAT_W;

  logic              latFull;
  logic [LAT_W-1:0]  latNext;
  logic [PROD_W-1:0] latSquare;
  logic [CNT_W:0]    cntWide;
  logic [SUM_W:0]    sumWide;
  logic [SQ_W:0]     sqWide;
  logic              tsStep;

  assign latFull   = &latCnt;
  assign latNext   = latFull ? latCnt : latCnt + 1'b1;
  assign latSquare = PROD_W'(latNext) * PROD_W'(latNext);
  assign cntWide   = {1'b0, cntAcc} + (CNT_W+1)'(1);
  assign sumWide   = {1'b0, sumAcc} + (SUM_W+1)'(latNext);
  assign sqWide    = {1'b0, sqAcc} + (SQ_W+1)'(latSquare);
  assign tsStep    = tickSel ? tickRise : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latCnt  <= '0;
      lastLat <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (strobe.startPulse) latCnt <= '0;
      else if (running) latCnt <= latNext;
      if (running && latFull) ovfFlag <= 1'b1;
      if (strobe.clearPulse) ovfFlag <= 1'b0;
      if (strobe.endPulse) lastLat <= latNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearPulse) begin
      minLat <= '1;
      maxLat <= '0;
      cntAcc <= '0;
      sumAcc <= '0;
      sqAcc  <= '0;
    end else if (strobe.endPulse) begin
      if (latNext < minLat) minLat <= latNext;
      if (latNext > maxLat) maxLat <= latNext;
      cntAcc <= cntWide[CNT_W] ? '1 : cntWide[CNT_W-1:0];
      sumAcc <= sumWide[SUM_W] ? '1 : sumWide[SUM_W-1:0];
      sqAcc  <= sqWide[SQ_W]   ? '1 : sqWide[SQ_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt <= '0;
      tsCap <= '0;
    end else begin
      if (tsStep) tsCnt <= tsCnt + 1'b1;
      if (trigRise) tsCap <= tsCnt;
    end
  end
endmodule

// File: rtl/irq_latency_unit.sv
module irq_latency_unit
  import ilm_pkg::*;
#(
  parameter int LAT_W       = 32,
  parameter int CNT_W       = 32,
  parameter int SUM_W       = 48,
  parameter int SQ_W        = 64,
  parameter int TS_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startTrial,
  input  logic             ackIrq,
  input  logic             clearStats,
  input  logic             tickSel,
  input  logic             extTick,
  input  logic             extTrigger,
  output logic             irqOut,
  output logic             trialActive,
  output logic [LAT_W-1:0] latencyNow,
  output logic [LAT_W-1:0] lastLatency,
  output logic             latOverflow,
  output logic [LAT_W-1:0] minLatency,
  output logic [LAT_W-1:0] maxLatency,
  output logic [CNT_W-1:0] sampleCount,
  output logic [SUM_W-1:0] sumLatency,
  output logic [SQ_W-1:0]  sumSquares,
  output logic [TS_W-1:0]  timeStamp,
  output logic [TS_W-1:0]  captureValue
);
  ilm_strobe_t strobe;
  logic        running, tickRise, trigRise;

  ilm_edge_sync #(.STAGES(SYNC_STAGES)) u_tickSync (
    .clk(clk), .rstN(rstN), .asyncIn(extTick), .riseOut(tickRise));
  ilm_edge_sync #(.STAGES(SYNC_STAGES)) u_trigSync (
    .clk(clk), .rstN(rstN), .asyncIn(extTrigger), .riseOut(trigRise));

  ilm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startTrial(startTrial), .ackIrq(ackIrq),
    .clearStats(clearStats), .strobe(strobe), .running(running));

  ilm_datapath #(
    .LAT_W(LAT_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .TS_W(TS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .running(running),
    .tickSel(tickSel), .tickRise(tickRise), .trigRise(trigRise),
    .latCnt(latencyNow), .lastLat(lastLatency), .ovfFlag(latOverflow),
    .minLat(minLatency), .maxLat(maxLatency), .cntAcc(sampleCount),
    .sumAcc(sumLatency), .sqAcc(sumSquares), .tsCnt(timeStamp),
    .tsCap(captureValue));

  assign irqOut      = running;
  assign trialActive = running;
endmodule

// File: rtl/ilm_checker.sv
module ilm_checker #(
  parameter int LAT_W = 32,
  parameter int CNT_W = 32,
  parameter int TS_W  = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             startTrial,
  input logic             ackIrq,
  input logic             clearStats,
  input logic             tickSel,
  input logic             irqOut,
  input logic [LAT_W-1:0] latencyNow,
  input logic             latOverflow,
  input logic [LAT_W-1:0] minLatency,
  input logic [LAT_W-1:0] maxLatency,
  input logic [CNT_W-1:0] sampleCount,
  input logic [TS_W-1:0]  timeStamp
);
  a_r2_start_raises: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && startTrial) |=> irqOut);

  a_r3_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ackIrq) |=> !irqOut);

  a_r3_idle_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !startTrial && !clearStats) |=> $stable(sampleCount));

  a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latOverflow) |-> (&latencyNow));

  a_r5_min_le_max: assert property (@(posedge clk) disable iff (!rstN)
    (sampleCount != '0) |-> (minLatency <= maxLatency));

  a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && ackIrq && !clearStats) |=> (sampleCount != '0));

  a_r8_ts_step: assert property (@(posedge clk) disable iff (!rstN)
    !tickSel |=> (timeStamp == TS_W'($past(timeStamp) + 1'b1)));
endmodule

bind irq_latency_unit ilm_checker #(.LAT_W(LAT_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rstN(rstN), .startTrial(startTrial), .ackIrq(ackIrq),
  .clearStats(clearStats), .tickSel(tickSel), .irqOut(irqOut),
  .latencyNow(latencyNow), .latOverflow(latOverflow), .minLatency(minLatency),
  .maxLatency(maxLatency), .sampleCount(sampleCount), .timeStamp(timeStamp));

// File: tb/irq_latency_unit_bench.sv
`timescale 1ns/1ps
module irq_latency_unit_bench;
  localparam int LAT_W = 8;
  localparam int CNT_W = 16;
  localparam int SUM_W = 12;
  localparam int SQ_W  = 16;
  localparam int TS_W  = 8;
  localparam longint LAT_MAX = (64'd1 << LAT_W) - 1;
  localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;
  localparam longint SUM_MAX = (64'd1 << SUM_W) - 1;
  localparam longint SQ_MAX  = (64'd1 << SQ_W) - 1;
  localparam longint TS_MOD  = 64'd1 << TS_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic startTrial = 0, ackIrq = 0, clearStats = 0, tickSel = 0, extTick = 0, extTrigger = 0;
  logic irqOut, trialActive, latOverflow;
  logic [LAT_W-1:0] latencyNow, lastLatency, minLatency, maxLatency;
  logic [CNT_W-1:0] sampleCount;
  logic [SUM_W-1:0] sumLatency;
  logic [SQ_W-1:0]  sumSquares;
  logic [TS_W-1:0]  timeStamp, captureValue;

  irq_latency_unit #(.LAT_W(LAT_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .TS_W(TS_W))
  u_irq_latency_unit (
    .clk(clk), .rstN(rstN), .startTrial(startTrial), .ackIrq(ackIrq),
    .clearStats(clearStats), .tickSel(tickSel), .extTick(extTick), .extTrigger(extTrigger),
    .irqOut(irqOut), .trialActive(trialActive), .latencyNow(latencyNow),
    .lastLatency(lastLatency), .latOverflow(latOverflow), .minLatency(minLatency),
    .maxLatency(maxLatency), .sampleCount(sampleCount), .sumLatency(sumLatency),
    .sumSquares(sumSquares), .timeStamp(timeStamp), .captureValue(captureValue));

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  longint mLast = 0, mMin = LAT_MAX, mMax = 0, mCnt = 0, mSum = 0, mSq = 0;
  bit mOvf = 0;

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint capAt(longint v, longint lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic modelClear();
    mMin = LAT_MAX; mMax = 0; mCnt = 0; mSum = 0; mSq = 0; mOvf = 0;
  endtask

  task automatic modelTrial(longint cycles, bit withClear);
    longint lat = capAt(cycles, LAT_MAX);
    mLast = lat;
    if (cycles > LAT_MAX) mOvf = 1;
    if (withClear) modelClear();
    else begin
      if (lat < mMin) mMin = lat;
      if (lat > mMax) mMax = lat;
      mCnt = capAt(mCnt + 1, CNT_MAX);
      mSum = capAt(mSum + lat, SUM_MAX);
      mSq  = capAt(mSq + lat * lat, SQ_MAX);
    end
  endtask

  task automatic checkStats(string req);
    chk({req, " lastLatency"}, lastLatency, mLast);
    chk({req, " minLatency"}, minLatency, mMin);
    chk({req, " maxLatency"}, maxLatency, mMax);
    chk({req, " sampleCount"}, sampleCount, mCnt);
    chk({req, " sumLatency"}, sumLatency, mSum);
    chk({req, " sumSquares"}, sumSquares, mSq);
    chk({req, " latOverflow"}, latOverflow, mOvf);
  endtask

  // start sampled at edge N, ack sampled at edge N+cycles
  task automatic runTrial(int cycles, bit withClear, bit restartMid);
    @(negedge clk); startTrial = 1;
    @(negedge clk); startTrial = 0;
    chk("R2 irq raised", irqOut, 1);
    for (int k = 1; k < cycles; k++) begin
      startTrial = (restartMid && k == 2);
      @(negedge clk);
    end
    startTrial = 0;
    ackIrq = 1; clearStats = withClear;
    @(negedge clk); ackIrq = 0; clearStats = 0;
    chk("R3 irq dropped", irqOut, 0);
    modelTrial(cycles, withClear);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    longint t0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqOut", irqOut, 0);
    checkStats("R1 reset");

    // R5 R6 sweep of short latencies
    for (int l = 1; l <= 24; l++) begin
      runTrial(l, 0, 0);
      checkStats("R5 R6 sweep");
    end
    // R2 restart during trial ignored
    runTrial(10, 0, 1);
    checkStats("R2 mid start");
    // R3 ack while idle ignored
    @(negedge clk); ackIrq = 1;
    @(negedge clk); ackIrq = 0;
    chk("R3 idle ack irq", irqOut, 0);
    checkStats("R3 idle ack");
    // R4 saturation boundary
    runTrial(255, 0, 0);
    checkStats("R4 exact max");
    runTrial(256, 0, 0);
    checkStats("R4 over max");
    runTrial(300, 0, 0);
    checkStats("R4 sticky");
    // R6 sum saturation
    for (int i = 0; i < 12; i++) runTrial(255, 0, 0);
    checkStats("R6 sum saturated");
    // R1 clear
    @(negedge clk); clearStats = 1;
    @(negedge clk); clearStats = 0;
    modelClear();
    checkStats("R1 clear");
    runTrial(9, 0, 0);
    checkStats("R5 first after clear");
    // R7 clear on completion edge
    runTrial(7, 1, 0);
    checkStats("R7 clear with ack");

    // R8 bus clock mode, incl. wrap
    tickSel = 0;
    @(negedge clk); t0 = timeStamp;
    repeat (300) @(negedge clk);
    chk("R8 clock mode wrap", timeStamp, (t0 + 300) % TS_MOD);
    // R8 external tick mode
    tickSel = 1;
    repeat (4) @(negedge clk);
    t0 = timeStamp;
    repeat (6) @(negedge clk);
    chk("R8 hold without ticks", timeStamp, t0);
    for (int p = 0; p < 5; p++) begin
      extTick = 1; repeat (3) @(negedge clk);
      extTick = 0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R8 tick count", timeStamp, (t0 + 5) % TS_MOD);

    // R9 capture
    tickSel = 0;
    for (int r = 0; r < 3; r++) begin
      repeat (3 + r * 7) @(negedge clk);
      t0 = timeStamp; extTrigger = 1;
      repeat (8) @(negedge clk);
      chk("R9 single capture", captureValue, (t0 + 2) % TS_MOD);
      extTrigger = 0;
      repeat (4) @(negedge clk);
      chk("R9 capture held", captureValue, (t0 + 2) % TS_MOD);
    end

    done = 1;
    finishRun();
  end
endmodule